// File: doc/BRIEF.md
# Clock-Keeping Base Timer with Buzzer

This block is a free-running divider chain that paces clock-keeping software. Each cycle of the fabric clock, a tick advances the chain by one. The tick is taken from one of three rate sources: a slow sub-clock enable strobe (nominally 32.768 kHz), the system clock itself (every cycle), or the enable strobe from the timer-0 prescaler. Two periodic events come from the chain. The long event fires once per full 14-bit wrap, which is 16384 ticks or half a second at 32.768 kHz. The short event fires at one of four selectable binary taps.

Each event sets a sticky flag. A write pulse clears the flag, and the flag feeds the shared interrupt line outside this block. The same chain drives a square-wave buzzer pin at tick/8 or tick/16, which is 4 kHz or 2 kHz at 32.768 kHz.

A change of rate source waits for the first enable of the newly requested source. The old source keeps advancing the chain until then, and the chain is never reset by the change. A run bit held low forces the chain to zero.

Top module: `base_timer`

## Requirements
- R1: Out of reset the chain is zero, both flags are low, the buzzer pin is low and the active source is the sub-clock.
- R2: With run high, the long flag rises on the tick that completes 16384 ticks counted from zero, and again every 16384 ticks after that.
- R3: The short flag rises each time the tick count reaches a multiple of its tap. Select code 0, 1, 2 or 3 gives a tap of 32, 128, 512 or 2048 ticks.
- R4: A flag stays set until its clear pulse is applied. After the pulse it reads low from the next cycle on.
- R5: When a clear pulse and a new event of the same flag fall in one cycle, the flag ends set.
- R6: With the buzzer enabled, the pin equals count bit 2 when buzzer select is 0 (period 8 ticks, high for counts 4..7 modulo 8). It equals count bit 3 when buzzer select is 1 (period 16 ticks).
- R7: With the buzzer enable low, the pin is low whatever the chain holds.
- R8: Source code 0 takes the sub-clock strobe, 1 the system clock (a tick every cycle), 2 the timer-0 prescaler strobe, and 3 behaves as 0. The chain advances only on ticks of the active source.
- R9: After the source code changes, the previous source keeps ticking until the first cycle in which the new source's strobe is high. That cycle is the first one counted on the new source, and the count is not reset.
- R10: While run is low, the chain is held at zero and neither flag can be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rstN | input | 1 | Active-low synchronous reset |
| subTick | input | 1 | Sub-clock enable strobe |
| t0Tick | input | 1 | Timer-0 prescaler enable strobe |
| runEn | input | 1 | Run bit; low holds the chain at zero |
| clkSel | input | 2 | Requested rate source code |
| shortSel | input | 2 | Short event tap select |
| buzzEn | input | 1 | Buzzer enable |
| buzzSel | input | 1 | Buzzer divide select (0: /8, 1: /16) |
| longClr | input | 1 | Clear pulse for the long flag |
| shortClr | input | 1 | Clear pulse for the short flag |
| longFlag | output | 1 | Sticky long overflow flag |
| shortFlag | output | 1 | Sticky short overflow flag |
| buzzOut | output | 1 | Buzzer square wave |

## Verification
A software clear of a flag can land in the same cycle as a fresh event that sets it again. The bench provokes this by restarting the chain from zero on the system source and counting exactly 31 ticks. It then applies the short clear together with the 32nd tick, and expects the flag to read high afterwards. A source switch and a tick of the old source can also coincide. The bench holds the requested strobe low while the old one keeps pulsing, and compares the count seen on the buzzer pin against an independent tick model on every cycle.

// File: rtl/base_timer_pkg.sv
package base_timer_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic tick;  // advance the chain by one
    logic hold;  // force the chain to zero
  } btStrobe_t;

  localparam int SRC_SEL_W = 2;
endpackage

// File: rtl/base_timer_ctrl.sv
module base_timer_ctrl
  import base_timer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 subTick,
  input  logic                 t0Tick,
  input  logic                 runEn,
  input  logic [SRC_SEL_W-1:0] clkSel,
  output btStrobe_t            strobe
);
  localparam int NUM_SRC = 1 << SRC_SEL_W;

  logic [NUM_SRC-1:0]   srcEn;
  logic [SRC_SEL_W-1:0] activeSel;
  logic [SRC_SEL_W-1:0] nextSel;
  logic                 reqEn;
  logic                 switchNow;

  // Source code map: 0 sub, 1 system, 2 timer-0, 3 sub
  always_comb begin
    srcEn    = '0;
    srcEn[0] = subTick;
    srcEn[1] = 1'b1;
    srcEn[2] = t0Tick;
    srcEn[3] = subTick;
  end

  assign reqEn     = srcEn[clkSel];
  assign switchNow = (clkSel != activeSel) && reqEn;
  assign nextSel   = switchNow ? clkSel : activeSel;

  always_ff @(posedge clk) begin
    if (!rstN) activeSel <= '0;
    else       activeSel <= nextSel;
  end

  assign strobe.tick = runEn && srcEn[nextSel];
  assign strobe.hold = !runEn;

  // R9: a pending switch with no strobe from the new source keeps the old one
  assert_switch_waits_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel != activeSel && !reqEn) |=> activeSel == $past(activeSel));
  // R10: no tick reaches the chain while run is low
  assert_no_tick_stopped_R10: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !strobe.tick);
endmodule

// File: rtl/base_timer_dp.sv
module base_timer_dp
  import base_timer_pkg::*;
#(
  parameter int CHAIN_W     = 14,
  parameter int NUM_TAPS    = 4,
  parameter int TAP_LOG2_LO = 5,
  parameter int TAP_STEP    = 2,
  parameter int BUZZ_BIT_LO = 2,
  parameter int NUM_BUZZ    = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  btStrobe_t                   strobe,
  input  logic [$clog2(NUM_TAPS)-1:0] shortSel,
  input  logic                        buzzEn,
  input  logic [$clog2(NUM_BUZZ)-1:0] buzzSel,
  input  logic                        longClr,
  input  logic                        shortClr,
  output logic                        longFlag,
  output logic                        shortFlag,
  output logic                        buzzOut
);
  logic [CHAIN_W-1:0]  cnt;
  logic [NUM_TAPS-1:0] tapFull;
  logic [NUM_BUZZ-1:0] buzzTap;
  logic                advance;
  logic                longHit;
  logic                shortHit;

  assign advance = strobe.tick && !strobe.hold;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.hold) cnt <= '0;
    else if (advance)         cnt <= cnt + 1'b1;
  end

  // One tap detector per selectable short period
  for (genvar g = 0; g < NUM_TAPS; g++) begin : gTap
    localparam int TW = TAP_LOG2_LO + TAP_STEP * g;
    assign tapFull[g] = &cnt[TW-1:0];
  end

  for (genvar b = 0; b < NUM_BUZZ; b++) begin : gBuzz
    assign buzzTap[b] = cnt[BUZZ_BIT_LO + b];
  end

  assign longHit  = advance && (&cnt);
  assign shortHit = advance && tapFull[shortSel];

  // Setting wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      longFlag  <= 1'b0;
      shortFlag <= 1'b0;
    end else begin
      longFlag  <= longHit  || (longFlag  && !longClr);
      shortFlag <= shortHit || (shortFlag && !shortClr);
    end
  end

  assign buzzOut = buzzEn && buzzTap[buzzSel];

  assert_hold_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> (cnt == '0 && !$rose(longFlag) && !$rose(shortFlag)));
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    advance |=> cnt == $past(cnt) + 1'b1);
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.hold) |=> $stable(cnt));
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (shortFlag && !shortClr) |=> shortFlag);
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    longHit |=> longFlag);
endmodule

// File: rtl/base_timer.sv
module base_timer
  import base_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       subTick,
  input  logic       t0Tick,
  input  logic       runEn,
  input  logic [1:0] clkSel,
  input  logic [1:0] shortSel,
  input  logic       buzzEn,
  input  logic       buzzSel,
  input  logic       longClr,
  input  logic       shortClr,
  output logic       longFlag,
  output logic       shortFlag,
  output logic       buzzOut
);
  btStrobe_t strobe;

  base_timer_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .subTick(subTick),
    .t0Tick (t0Tick),
    .runEn  (runEn),
    .clkSel (clkSel),
    .strobe (strobe)
  );

  base_timer_dp #(
    .CHAIN_W    (14),
    .NUM_TAPS   (4),
    .TAP_LOG2_LO(5),
    .TAP_STEP   (2),
    .BUZZ_BIT_LO(2),
    .NUM_BUZZ   (2)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .shortSel (shortSel),
    .buzzEn   (buzzEn),
    .buzzSel  (buzzSel),
    .longClr  (longClr),
    .shortClr (shortClr),
    .longFlag (longFlag),
    .shortFlag(shortFlag),
    .buzzOut  (buzzOut)
  );
endmodule

// File: tb/sim_base_timer.sv
module sim_base_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic subTick = 1'b0, t0Tick = 1'b0, runEn = 1'b0;
  logic [1:0] clkSel = 2'd1, shortSel = 2'd0;
  logic buzzEn = 1'b0, buzzSel = 1'b0, longClr = 1'b0, shortClr = 1'b0;
  logic longFlag, shortFlag, buzzOut;

  int checks = 0;
  int errors = 0;
  int mCnt = 0;
  int mAct = 0;
  bit mLong = 0, mShort = 0;
  bit done = 0;

  always #10 clk = ~clk;

  base_timer u0 (
    .clk(clk), .rstN(rstN), .subTick(subTick), .t0Tick(t0Tick),
    .runEn(runEn), .clkSel(clkSel), .shortSel(shortSel), .buzzEn(buzzEn),
    .buzzSel(buzzSel), .longClr(longClr), .shortClr(shortClr),
    .longFlag(longFlag), .shortFlag(shortFlag), .buzzOut(buzzOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit srcOn(input int s, input bit sb, input bit tz);
    case (s)
      1: return 1'b1;
      2: return tz;
      default: return sb;
    endcase
  endfunction

  // One clock: drive, let the edge pass, update the model, compare
  task automatic step(input bit sb, input bit tz, input bit cl, input bit cs,
                      input string tag);
    int nxt, tap;
    bit tk, hitL, hitS;
    subTick = sb; t0Tick = tz; longClr = cl; shortClr = cs;
    @(posedge clk);
    @(negedge clk);
    nxt = (int'(clkSel) != mAct && srcOn(int'(clkSel), sb, tz)) ? int'(clkSel) : mAct;
    tk = runEn && srcOn(nxt, sb, tz);
    mAct = nxt;
    tap = 32 << (2 * int'(shortSel));
    hitL = tk && mCnt == 16383;
    hitS = tk && (mCnt % tap) == tap - 1;
    if (!runEn) mCnt = 0;
    else if (tk) mCnt = (mCnt + 1) % 16384;
    mLong = hitL || (mLong && !cl);
    mShort = hitS || (mShort && !cs);
    subTick = 0; t0Tick = 0; longClr = 0; shortClr = 0;
    check({tag, " longFlag"}, longFlag, mLong);
    check({tag, " shortFlag"}, shortFlag, mShort);
    check({tag, " buzzOut"}, buzzOut,
          buzzEn ? ((mCnt >> (2 + int'(buzzSel))) & 1) : 0);
  endtask

  task automatic restart(input string tag);
    runEn = 0;
    step(0, 0, 1, 1, tag);
    runEn = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1 longFlag", longFlag, 0);
    check("R1 shortFlag", shortFlag, 0);
    check("R1 buzzOut", buzzOut, 0);

    // R3: each short tap on the system source (R8 code 1)
    clkSel = 2'd1;
    for (int s = 0; s < 4; s++) begin
      int tap;
      shortSel = 2'(s);
      tap = 32 << (2 * s);
      restart("R10 restart");
      for (int i = 0; i < tap - 1; i++) step(0, 0, 0, 0, "R3 pre");
      check("R3 before tap", shortFlag, 0);
      step(0, 0, 0, 0, "R3 at tap");
      check("R3 at tap", shortFlag, 1);
    end

    // R4: sticky until cleared
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, "R4 hold");
    check("R4 still set", shortFlag, 1);
    step(0, 0, 0, 1, "R4 clear");
    check("R4 cleared", shortFlag, 0);

    // R5: clear and event in the same cycle
    shortSel = 2'd0;
    restart("R5 restart");
    for (int i = 0; i < 31; i++) step(0, 0, 0, 0, "R5 pre");
    step(0, 0, 0, 1, "R5 clash");
    check("R5 set wins", shortFlag, 1);

    // R2: long overflow over one full wrap
    shortSel = 2'd3;
    restart("R2 restart");
    for (int i = 0; i < 16383; i++) step(0, 0, 0, 0, "R2 pre");
    check("R2 before wrap", longFlag, 0);
    step(0, 0, 0, 0, "R2 wrap");
    check("R2 at wrap", longFlag, 1);

    // R6 and R7: buzzer taps and enable
    restart("R6 restart");
    buzzEn = 1;
    buzzSel = 0;
    for (int i = 0; i < 32; i++) step(0, 0, 0, 0, "R6 div8");
    buzzSel = 1;
    for (int i = 0; i < 48; i++) step(0, 0, 0, 0, "R6 div16");
    buzzEn = 0;
    for (int i = 0; i < 16; i++) begin
      step(0, 0, 0, 0, "R7 off");
      check("R7 pin low", buzzOut, 0);
    end

    // R10: run low holds zero while ticks arrive
    buzzEn = 1;
    buzzSel = 0;
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, "R10 count up");
    runEn = 0;
    for (int i = 0; i < 8; i++) step(1, 1, 1, 1, "R10 held");
    check("R10 flags clear", shortFlag, 0);
    runEn = 1;
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R10 resume");
    check("R10 buzz at 4", buzzOut, 1);

    // R8: sub-clock source (code 0 then code 3), strobe every third cycle
    for (int c = 0; c < 4; c += 3) begin
      clkSel = 2'(c);
      shortSel = 2'd0;
      restart("R8 restart");
      for (int i = 0; i < 96; i++) step(i % 3 == 2, 0, 0, 0, "R8 sub");
      check("R8 sub 32 ticks", shortFlag, 1);
    end

    // R9: request timer-0 while only sub strobes arrive
    clkSel = 2'd2;
    for (int i = 0; i < 24; i++) step(i % 2 == 0, 0, 0, 0, "R9 pending");
    for (int i = 0; i < 20; i++) step(1, i % 4 == 3, 0, 0, "R9 switched");
    // R9: back to system, chain not reset
    clkSel = 2'd1;
    for (int i = 0; i < 40; i++) step(0, 0, 0, 0, "R9 to sys");

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule